// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

This block adds two unsigned operands of a configurable width together with a single carry-in bit. It returns the sum and a carry-out. It contains no registers and no clock. The result settles within the same cycle that the operands change, so the block can sit between the pipeline registers of a datapath such as a wide accumulator or a filter tap sum.

Carries do not ripple from bit to bit. Each bit first forms a local generate and a local propagate. A prefix tree with a logarithmic number of levels then merges these into group terms. At each level, a position merges with the position a power-of-two distance below it, so every node drives at most two nodes of the next level. The last level keeps only the group generate, because the final carries are all that remains to compute. The carry-in enters as an extra generate just below bit 0. A final stage XORs each local propagate with the carry into that bit.

The operands have no valid/ready handshake. The block is pure logic, so it never stalls a stream around it and never holds a value. Whatever handshake the surrounding pipeline uses passes around this block without changes.

Top module: `prefix_adder`

## Requirements
- R1: For every operand pair and carry-in, the concatenation {carry_out, sum} equals op_a + op_b + carry_in computed at W+1 bits. The default W is 32, and any W of 1 or more needs no source edits.
- R2: When op_a is all ones, op_b is zero and carry_in is 1, sum is zero and carry_out is 1. The carry travels across the full width.
- R3: When op_a and op_b have no set bit in common and together cover every bit, so that every bit propagates, every sum bit equals the inverse of carry_in and carry_out equals carry_in.
- R4: When both operands are zero, sum equals carry_in zero-extended and carry_out is 0.
- R5: Bit 0 of sum always equals op_a[0] XOR op_b[0] XOR carry_in.
- R6: When bit W-1 of both operands is set, carry_out is 1 whatever the lower bits and carry_in are.
- R7: When bit W-1 of both operands is clear, carry_out is 0 whatever the lower bits and carry_in are.
- R8: The outputs depend only on the present inputs. A new operand pair applied after a clock edge shows its result before the next falling edge, and an earlier input pair leaves no trace in it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand, unsigned |
| op_b | input | W | Second operand, unsigned |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of the total |
| carry_out | output | 1 | Carry out of bit W-1 |

## Verification
A wrong merge in one prefix cell corrupts the group generate of a whole span. At the ports this shows up as wrong sum bits at and above the span, and often as a wrong carry_out, for the same input vector. No state is stored, so the error appears in the same cycle and disappears when the inputs change. Long carry chains (all-ones plus one, fully propagating patterns) are the inputs that reach the cells on the upper tree levels. The random pairs cover the short spans.

// File: rtl/kpa_pkg.sv
package kpa_pkg;
  // Number of prefix levels for a given width; one level minimum so that
  // the stage arrays never collapse to zero size.
  function automatic int prefix_levels(input int width);
    int lv;
    lv = 0;
    while ((1 << lv) < width) lv++;
    if (lv < 1) lv = 1;
    return lv;
  endfunction

  // Combining distance at a given level.
  function automatic int level_span(input int level);
    return 1 << level;
  endfunction
endpackage

// File: rtl/kpa_pg_stage.sv
module kpa_pg_stage #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_o[i]  = a_in[i] & b_in[i];
    assign prop_o[i] = a_in[i] ^ b_in[i];
  end
endmodule

// File: rtl/kpa_black_cell.sv
module kpa_black_cell (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_out,
  output logic p_out
);
`ifdef KPA_CELL_DELAY
  assign #1 g_out = g_hi | (p_hi & g_lo);
  assign #1 p_out = p_hi & p_lo;
`else
  assign g_out = g_hi | (p_hi & g_lo);
  assign p_out = p_hi & p_lo;
`endif
endmodule

// File: rtl/kpa_gray_cell.sv
module kpa_gray_cell (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  output logic g_out
);
`ifdef KPA_CELL_DELAY
  assign #1 g_out = g_hi | (p_hi & g_lo);
`else
  assign g_out = g_hi | (p_hi & g_lo);
`endif
endmodule

// File: rtl/kpa_prefix_tree.sv
module kpa_prefix_tree
  import kpa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] gen_i,
  input  logic [W-1:0] prop_i,
  input  logic         cin,
  output logic [W-1:0] grp_gen_o
);
  localparam int LV = prefix_levels(W);

  // gs[k] / ps[k]: group terms entering level k
  logic [LV:0][W-1:0]   gs;
  logic [LV-1:0][W-1:0] ps;

  // Carry-in folded in as a generate just below bit 0
  assign gs[0][0] = gen_i[0] | (prop_i[0] & cin);
  assign ps[0][0] = prop_i[0];
  if (W > 1) begin : g_seed
    assign gs[0][W-1:1] = gen_i[W-1:1];
    assign ps[0][W-1:1] = prop_i[W-1:1];
  end

  for (genvar k = 0; k < LV; k++) begin : g_lvl
    localparam int D = level_span(k);
    for (genvar i = 0; i < W; i++) begin : g_pos
      if (i < D) begin : g_pass
        assign gs[k+1][i] = gs[k][i];
        if (k < LV - 1) begin : g_pp
          assign ps[k+1][i] = ps[k][i];
        end
      end else if (k < LV - 1) begin : g_black
        kpa_black_cell u_cell (
          .g_hi (gs[k][i]),
          .p_hi (ps[k][i]),
          .g_lo (gs[k][i-D]),
          .p_lo (ps[k][i-D]),
          .g_out(gs[k+1][i]),
          .p_out(ps[k+1][i])
        );
      end else begin : g_gray
        kpa_gray_cell u_cell (
          .g_hi (gs[k][i]),
          .p_hi (ps[k][i]),
          .g_lo (gs[k][i-D]),
          .g_out(gs[k+1][i])
        );
      end
    end
  end

  assign grp_gen_o = gs[LV];
endmodule

// File: rtl/kpa_sum_stage.sv
module kpa_sum_stage #(
  parameter int W = 32
) (
  input  logic [W-1:0] prop_i,
  input  logic [W-1:0] grp_gen_i,
  input  logic         cin,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] carry;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign carry[i] = cin;
    end else begin : g_up
      assign carry[i] = grp_gen_i[i-1];
    end
    assign sum_o[i] = prop_i[i] ^ carry[i];
  end

  assign cout_o = grp_gen_i[W-1];
endmodule

// File: rtl/prefix_adder.sv
module prefix_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_prop;
  logic [W-1:0] grp_gen;

  kpa_pg_stage #(.W(W)) u_pg (
    .a_in  (op_a),
    .b_in  (op_b),
    .gen_o (bit_gen),
    .prop_o(bit_prop)
  );

  kpa_prefix_tree #(.W(W)) u_tree (
    .gen_i    (bit_gen),
    .prop_i   (bit_prop),
    .cin      (carry_in),
    .grp_gen_o(grp_gen)
  );

  kpa_sum_stage #(.W(W)) u_sum (
    .prop_i   (bit_prop),
    .grp_gen_i(grp_gen),
    .cin      (carry_in),
    .sum_o    (sum),
    .cout_o   (carry_out)
  );
endmodule

// File: rtl/prefix_adder_chk.sv
module prefix_adder_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         carry_in,
  input logic [W-1:0] sum,
  input logic         carry_out
);
`ifndef KPA_CELL_DELAY
  logic [W:0] ref_total;
  assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};

  always_comb begin
    // R1
    total_match_chk: assert ({carry_out, sum} == ref_total)
      else $error("total mismatch");
    // R3
    full_prop_chk: assert (!(((op_a ^ op_b) == {W{1'b1}}) && ((op_a & op_b) == '0))
                           || (sum == {W{~carry_in}} && carry_out == carry_in))
      else $error("full propagate wrong");
    // R4
    zero_sum_chk: assert (!(op_a == '0 && op_b == '0)
                          || (sum == {{(W-1){1'b0}}, carry_in} && !carry_out))
      else $error("zero operands wrong");
    // R5
    lsb_sum_chk: assert (sum[0] == (op_a[0] ^ op_b[0] ^ carry_in))
      else $error("bit 0 wrong");
    // R6
    top_gen_chk: assert (!(op_a[W-1] && op_b[W-1]) || carry_out)
      else $error("top generate lost");
    // R7
    top_kill_chk: assert (op_a[W-1] || op_b[W-1] || !carry_out)
      else $error("top kill ignored");
  end
`endif
endmodule

bind prefix_adder prefix_adder_chk #(.W(W)) u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .carry_in (carry_in),
  .sum      (sum),
  .carry_out(carry_out)
);

// File: tb/prefix_adder_test.sv
module prefix_adder_test;
  localparam int WIDTH   = 32;
  localparam int NUM_VEC = 2000;

  typedef struct {
    logic [WIDTH-1:0] exp_sum;
    logic             exp_cout;
    string            tag;
  } item_t;

  logic             clk = 1'b0;
  logic [WIDTH-1:0] a = '0;
  logic [WIDTH-1:0] b = '0;
  logic             ci = 1'b0;
  logic [WIDTH-1:0] s;
  logic             co;
  int               n_run = 0;
  int               n_fail = 0;
  bit               done = 0;
  item_t            sb[$];

  always #5 clk = ~clk;

  prefix_adder #(.W(WIDTH)) uut (
    .op_a(a), .op_b(b), .carry_in(ci), .sum(s), .carry_out(co)
  );

  // Driver: apply one vector just after a rising edge, queue its expectation
  task automatic apply(input logic [WIDTH-1:0] va, input logic [WIDTH-1:0] vb,
                       input logic vc, input string tag);
    logic [WIDTH:0] tot;
    item_t it;
    @(posedge clk);
    #1;
    a = va; b = vb; ci = vc;
    tot = {1'b0, va} + {1'b0, vb} + {{WIDTH{1'b0}}, vc};
    it.exp_sum = tot[WIDTH-1:0];
    it.exp_cout = tot[WIDTH];
    it.tag = tag;
    sb.push_back(it);
  endtask

  function automatic logic [WIDTH-1:0] rnd_word();
    logic [WIDTH-1:0] w;
    for (int i = 0; i < WIDTH; i++) w[i] = 1'($urandom);
    return w;
  endfunction

  // Monitor: compare at the falling edge, half a cycle after the drive
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_run++;
      if (s !== it.exp_sum || co !== it.exp_cout) begin
        n_fail++;
        $display("FAIL %s: got cout=%0b sum=%h, expected cout=%0b sum=%h",
                 it.tag, co, s, it.exp_cout, it.exp_sum);
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      finish_run();
    end
  end

  initial begin
    logic [WIDTH-1:0] alt;
    for (int i = 0; i < WIDTH; i++) alt[i] = i[0];
    // R4: zero plus zero (also the idle output state)
    apply('0, '0, 1'b0, "R4 zero+zero cin0");
    apply('0, '0, 1'b1, "R4 zero+zero cin1");
    // R2: carry across the full width
    apply('1, '0, 1'b1, "R2 ones+0+1");
    apply('1, {{(WIDTH-1){1'b0}}, 1'b1}, 1'b0, "R2 ones+1");
    // R3: every bit propagates
    apply(alt, ~alt, 1'b0, "R3 alt prop cin0");
    apply(alt, ~alt, 1'b1, "R3 alt prop cin1");
    apply('1, '0, 1'b0, "R3 ones prop cin0");
    // R5: low bit with and without carry-in
    apply({{(WIDTH-1){1'b0}}, 1'b1}, '0, 1'b1, "R5 lsb 1+cin");
    apply({{(WIDTH-1){1'b0}}, 1'b1}, {{(WIDTH-1){1'b0}}, 1'b1}, 1'b0, "R5 lsb 1+1");
    // R6: both top bits set
    apply({1'b1, {(WIDTH-1){1'b0}}}, {1'b1, {(WIDTH-1){1'b0}}}, 1'b0, "R6 top gen");
    apply(alt | {1'b1, {(WIDTH-1){1'b0}}}, alt | {1'b1, {(WIDTH-1){1'b0}}}, 1'b1, "R6 top gen alt");
    // R7: both top bits clear, lower bits saturated
    apply({1'b0, {(WIDTH-1){1'b1}}}, {1'b0, {(WIDTH-1){1'b1}}}, 1'b1, "R7 top kill");
    // R8: back-to-back distinct vectors, no memory of the previous one
    apply('1, '1, 1'b1, "R8 max then min");
    apply('0, '0, 1'b0, "R8 min after max");
    // R1: random pairs with random carry-in
    for (int n = 0; n < NUM_VEC; n++)
      apply(rnd_word(), rnd_word(), 1'($urandom), "R1 random");
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    finish_run();
  end
endmodule